// File: doc/BRIEF.md
# Framed Word Serializer with Two Slot Cadences

This block turns 12-bit parallel words into a framed serial bit stream, one bit per bit-clock cycle. Time on the line is divided into word slots. A slot that carries a word begins with a two-bit start marker (a one, then a zero), followed by the twelve payload bits, most significant bit first. A slot with nothing to carry is sent as all zeros. A companion qualifier output changes on the same clock edge as each serial bit, so a receiver can use it as a forwarded bit clock.

Two cadences are available. In the standard cadence every slot lasts 14 bit times, so the bit rate is 14 times the word reference rate. In the over-clocked cadence the slot lengths cycle through 14, 14 and 16 bit times, and the two extra bits of each long slot are always zero. Words come in as single-cycle valid pulses that are already synchronised to the bit clock. One word can wait in a holding register while another is on the line. A word that arrives while the holding register is still full is dropped, and a sticky overflow flag is raised. Dropping the enable returns the block to a quiet state: the next slot starts on the first cycle after the enable comes back. The cadence select should only be changed while the block is disabled.

Top module: `word_framer`

## Requirements
- R1: A slot that carries a word puts out, in this order: bit value 1, bit value 0, then the 12 payload bits from bit 11 down to bit 0, one bit per enabled cycle.
- R2: With `over_mode`=1, slot lengths repeat as 14, 14, 16 bit times, counted from the first slot after enable. With `over_mode`=0, every slot is 14 bit times.
- R3: The last two bits of every 16-bit slot are 0, whether or not the slot carries a word.
- R4: When the holding register is empty at the first cycle of a slot, every bit of that slot is 0.
- R5: A word with `wr_vld`=1 is captured into the holding register in that cycle and sent in the next slot that starts after that cycle. A word that arrives in the first cycle of a slot waits for the following slot.
- R6: A `wr_vld` pulse that arrives while the holding register is full, and not in the first cycle of a slot, is discarded and sets `ovf`. `ovf` then stays 1 for as long as `en` stays 1.
- R7: While `en`=0, from the next clock edge on, `ser_bit`, `bit_qual` and `ovf` are 0, the holding register is empty, `wr_vld` is ignored, and the slot position and cadence phase are reset. The first enabled cycle starts slot 0.
- R8: `bit_qual` is 1 exactly in the cycles in which `ser_bit` carries a slot bit: it follows `en` by one clock edge and changes on the same edge as `ser_bit`.
- R9: While `rst_n`=0, `ser_bit`, `bit_qual` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; 0 forces the block quiet |
| over_mode | input | 1 | 1 selects the 14/14/16 cadence, 0 selects all-14 slots |
| wr_vld | input | 1 | Single-cycle pulse marking a new word |
| wr_data | input | 12 | Parallel word, taken when wr_vld is 1 |
| ser_bit | output | 1 | Serial data bit |
| bit_qual | output | 1 | Forwarded bit qualifier, aligned with ser_bit |
| ovf | output | 1 | Sticky flag: a word was lost to a full holding register |

## Verification
Some properties are checked on every cycle by the bound assertions. These are: the first bit of each slot (the marker when a word is held, zero when the slot is idle), the zero tail bits of long slots, that two slot starts never follow each other directly, how the holding register empties and how the overflow flag is set and kept, and the quiet state while disabled. Other behaviour shows up only in the bench's scenarios, where the received stream is rebuilt slot by slot from its own count of the cadence. These are: that the payload arrives intact and in order, that the slot lengths follow the 14/14/16 pattern, which slot a word lands in when it arrives on a slot boundary, that the word causing an overflow is the one discarded, and that words offered while disabled never appear.

// File: rtl/word_framer_pkg.sv
`timescale 1ns/1ps
package word_framer_pkg;
  parameter int WORD_W   = 12;
  parameter int MARK_W   = 2;
  parameter int PAD_W    = 2;
  parameter int CADENCE  = 3;
  parameter int BASE_LEN = MARK_W + WORD_W;
  parameter int LONG_LEN = BASE_LEN + PAD_W;
  parameter int FRAME_W  = LONG_LEN;
  parameter int POS_W    = $clog2(LONG_LEN);
  parameter int PH_W     = $clog2(CADENCE);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [POS_W-1:0]   pos_t;
  typedef logic [PH_W-1:0]    phase_t;
  typedef logic [POS_W:0]     len_t;

  // marker is a one followed by zeros
  parameter logic [MARK_W-1:0] MARKER = {1'b1, {(MARK_W-1){1'b0}}};

  // length of a slot in bit times for a given cadence phase
  function automatic len_t slot_len(input logic over, input phase_t ph);
    if (over && ph == PH_W'(CADENCE-1)) return len_t'(LONG_LEN);
    return len_t'(BASE_LEN);
  endfunction

  // full-width frame, transmitted from the top bit down
  function automatic frame_t build_frame(input word_t w);
    return {MARKER, w, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/word_framer_slot_timer.sv
`timescale 1ns/1ps
module word_framer_slot_timer
  import word_framer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic over_mode,
  output logic slot_start,
  output logic tail_bit
);
  pos_t   pos;
  phase_t phase;
  len_t   len;
  logic   last;

  always_comb begin
    len        = slot_len(over_mode, phase);
    last       = ({1'b0, pos} == len - 1'b1);
    slot_start = en && (pos == '0);
    tail_bit   = en && ({1'b0, pos} >= len_t'(BASE_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      phase <= '0;
    end else if (!en) begin
      pos   <= '0;
      phase <= '0;
    end else if (last) begin
      pos   <= '0;
      phase <= (phase == PH_W'(CADENCE-1)) ? '0 : phase + 1'b1;
    end else begin
      pos   <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/word_framer_hold.sv
`timescale 1ns/1ps
module word_framer_hold
  import word_framer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  slot_start,
  input  logic  wr_vld,
  input  word_t wr_data,
  output logic  hold_vld,
  output word_t hold_data,
  output logic  ovf
);
  logic clash;

  assign clash = wr_vld && hold_vld && !slot_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
      ovf       <= 1'b0;
    end else if (!en) begin
      hold_vld  <= 1'b0;
      ovf       <= 1'b0;
    end else if (slot_start) begin
      // the slot takes the held word; a new arrival refills the register
      hold_vld <= wr_vld;
      if (wr_vld) hold_data <= wr_data;
    end else if (clash) begin
      ovf <= 1'b1;
    end else if (wr_vld) begin
      hold_vld  <= 1'b1;
      hold_data <= wr_data;
    end
  end
endmodule

// File: rtl/word_framer_shifter.sv
`timescale 1ns/1ps
module word_framer_shifter
  import word_framer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  slot_start,
  input  logic  hold_vld,
  input  word_t hold_data,
  output logic  ser_bit,
  output logic  bit_qual
);
  frame_t shreg;
  frame_t load_frame;

  always_comb begin
    load_frame = hold_vld ? build_frame(hold_data) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      ser_bit  <= 1'b0;
      bit_qual <= 1'b0;
    end else if (!en) begin
      shreg    <= '0;
      ser_bit  <= 1'b0;
      bit_qual <= 1'b0;
    end else begin
      bit_qual <= 1'b1;
      if (slot_start) begin
        ser_bit <= load_frame[FRAME_W-1];
        shreg   <= load_frame << 1;
      end else begin
        ser_bit <= shreg[FRAME_W-1];
        shreg   <= shreg << 1;
      end
    end
  end
endmodule

// File: rtl/word_framer.sv
`timescale 1ns/1ps
module word_framer
  import word_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              over_mode,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_data,
  output logic              ser_bit,
  output logic              bit_qual,
  output logic              ovf
);
  // named internal events, watched by the bound checker
  logic  slot_start;
  logic  tail_bit;
  logic  hold_vld;
  word_t hold_data;

  word_framer_slot_timer timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .over_mode  (over_mode),
    .slot_start (slot_start),
    .tail_bit   (tail_bit)
  );

  word_framer_hold hold_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .slot_start (slot_start),
    .wr_vld     (wr_vld),
    .wr_data    (wr_data),
    .hold_vld   (hold_vld),
    .hold_data  (hold_data),
    .ovf        (ovf)
  );

  word_framer_shifter shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .slot_start (slot_start),
    .hold_vld   (hold_vld),
    .hold_data  (hold_data),
    .ser_bit    (ser_bit),
    .bit_qual   (bit_qual)
  );
endmodule

// File: rtl/word_framer_checker.sv
`timescale 1ns/1ps
module word_framer_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_vld,
  input logic slot_start,
  input logic tail_bit,
  input logic hold_vld,
  input logic ser_bit,
  input logic bit_qual,
  input logic ovf
);
  assert_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && hold_vld |=> ser_bit);

  assert_slot_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);

  assert_tail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tail_bit |=> !ser_bit);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !hold_vld |=> !ser_bit);

  assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !wr_vld |=> !hold_vld);

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr_vld && hold_vld && !slot_start |=> ovf);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && ovf |=> ovf);

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ser_bit && !bit_qual && !ovf && !hold_vld);

  assert_qual_follows_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> bit_qual);
endmodule

bind word_framer word_framer_checker chk_i (.*);

// File: tb/word_framer_tb_top.sv
`timescale 1ns/1ps
module word_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        over_mode = 1'b0;
  logic        wr_vld = 1'b0;
  logic [11:0] wr_data = '0;
  logic        ser_bit, bit_qual, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cur_over = 1'b0;
  logic [11:0] exp_q[$];

  logic [15:0] mb;
  int mcnt = 0;
  int mph = 0;
  int mlen;

  always #10 clk = ~clk;

  word_framer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .over_mode(over_mode),
    .wr_vld(wr_vld), .wr_data(wr_data),
    .ser_bit(ser_bit), .bit_qual(bit_qual), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: one-cycle pulse, expected words go to the scoreboard queue
  task automatic send_word(input logic [11:0] d, input bit keep);
    wr_vld = 1'b1;
    wr_data = d;
    if (keep) exp_q.push_back(d);
    @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // judge one complete slot rebuilt from the line
  task automatic eval_slot(input int len);
    logic [11:0] got;
    logic [11:0] exp;
    bit nz;
    if (mb[0] && !mb[1]) begin
      for (int i = 0; i < 12; i++) got[11-i] = mb[2+i];
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected word", int'(got), 0);
      end else begin
        exp = exp_q.pop_front();
        chk(got == exp, cur_over ? "R2 payload in over-clocked cadence" : "R1 payload", int'(got), int'(exp));
      end
    end else begin
      nz = 1'b0;
      for (int i = 0; i < len; i++) if (mb[i]) nz = 1'b1;
      chk(!nz, "R4 idle slot not zero", int'(mb), 0);
    end
    if (len == 16) chk(mb[15:14] == 2'b00, "R3 long slot tail", int'(mb[15:14]), 0);
  endtask

  // monitor: counts slots with its own cadence model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!bit_qual) begin
        chk(ser_bit == 1'b0, "R7 ser_bit while quiet", int'(ser_bit), 0);
        mcnt = 0;
        mph = 0;
      end else begin
        mb[mcnt] = ser_bit;
        mcnt++;
        mlen = (cur_over && mph == 2) ? 16 : 14;
        if (mcnt == mlen) begin
          eval_slot(mlen);
          mcnt = 0;
          mph = (mph + 1) % 3;
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_bit == 1'b0, "R9 ser_bit in reset", int'(ser_bit), 0);
    chk(bit_qual == 1'b0, "R9 bit_qual in reset", int'(bit_qual), 0);
    chk(ovf == 1'b0, "R9 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // standard cadence: back-to-back and sparse words
    cur_over = 1'b0; over_mode = 1'b0;
    en = 1'b1;
    @(negedge clk);
    chk(bit_qual == 1'b1, "R8 qualifier after enable", int'(bit_qual), 1);
    for (int i = 0; i < 6; i++) begin
      send_word(12'hA5C ^ 12'(i * 12'h137), 1'b1);
      repeat (13) @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      send_word(12'h0F1 + 12'(i * 12'h311), 1'b1);
      repeat (22) @(negedge clk);
    end
    send_word(12'hFFF, 1'b1);
    repeat (13) @(negedge clk);
    send_word(12'h001, 1'b1);
    wait_drain();
    en = 1'b0;
    @(negedge clk);
    chk(bit_qual == 1'b0, "R8 qualifier after disable", int'(bit_qual), 0);

    // over-clocked cadence
    cur_over = 1'b1; over_mode = 1'b1;
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 9; i++) begin
      send_word(12'h9C3 ^ 12'(i * 12'h0B5), 1'b1);
      repeat (15) @(negedge clk);
    end
    wait_drain();
    repeat (60) @(negedge clk);
    en = 1'b0;
    @(negedge clk);

    // word arriving in a slot's first cycle waits one slot
    cur_over = 1'b0; over_mode = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (14) @(negedge clk);
    send_word(12'h3C9, 1'b1);
    chk(ser_bit == 1'b0, "R5 word on slot boundary sent too early", int'(ser_bit), 0);
    repeat (14) @(negedge clk);
    chk(ser_bit == 1'b1, "R5 marker in following slot", int'(ser_bit), 1);
    wait_drain();
    en = 1'b0;
    @(negedge clk);

    // overflow: second word while holding register is full
    @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
    send_word(12'h5A6, 1'b1);
    chk(ovf == 1'b0, "R6 no overflow on single word", int'(ovf), 0);
    send_word(12'hC33, 1'b0);
    chk(ovf == 1'b1, "R6 overflow raised", int'(ovf), 1);
    send_word(12'h777, 1'b0);
    wait_drain();
    chk(ovf == 1'b1, "R6 overflow sticky", int'(ovf), 1);
    en = 1'b0;
    @(negedge clk);
    chk(ovf == 1'b0, "R7 overflow cleared by disable", int'(ovf), 0);

    // words offered while disabled are ignored
    send_word(12'hFFF, 1'b0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (45) @(negedge clk);
    chk(ovf == 1'b0, "R7 no overflow from ignored word", int'(ovf), 0);
    en = 1'b0;
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R5 words left unsent", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule